// File: doc/BRIEF.md
# Dual-Rail Completion Detector Tree

This block watches a bus of `N` dual-rail bits that move under a four-phase handshake. Every bit is carried on a true wire and a false wire. Each bit is decoded on its own into a "holds a value" flag, a data value and an illegal-code flag. The per-bit flags are merged by a balanced tree of two-input Muller C-elements. Each C-element keeps its state in a clocked register. The root of the tree is the total completion signal for the whole bus.

The completion output goes high once every bit carries a value and goes low once every bit has returned to the spacer. While some bits are valid and others are spacers, it keeps its last value. A sender uses the rising edge to learn that a word has fully arrived, and the falling edge to learn that the bus has been cleared before the next word. The block also presents the decoded word while completion is high, and raises an error flag whenever a bit shows the forbidden code.

Top module: `dr_completion_tree`

## Requirements
- R1: The bit code is {true, false}: (1,0) is logic 1, (0,1) is logic 0, (0,0) is the spacer and (1,1) is illegal. A bit counts as holding a value when at least one of its rails is high.
- R2: After reset, `done_o`, `data_o` and `err_o` are all 0.
- R3: When all bits go from spacer to valid codes and are held there, `done_o` rises exactly D = ceil(log2 N) clock edges later, and not earlier.
- R4: When all bits go from valid codes back to spacer and are held there, `done_o` falls exactly D clock edges later, and not earlier.
- R5: While `done_o` is 0, a bus that mixes spacers and valid bits never raises `done_o`, however long it is held.
- R6: While `done_o` is 1, a bus that mixes spacers and valid bits never lowers `done_o`, however long it is held.
- R7: While `done_o` is 1 and the bus is held stable, `data_o` equals the decoded word, with bit i at position i. While `done_o` is 0, `data_o` is all zeros.
- R8: `err_o` is 1 in the cycle after any bit shows (1,1), and 0 in the cycle after no bit does.
- R9: Each C-element sets when both inputs are 1, clears when both are 0, and otherwise holds.
- R10: When N is not a power of two, the unused tree leaves copy the highest real bit, so R3 to R6 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the C-element state and the output registers |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | N | True rails, one per bit |
| rail_f | input | N | False rails, one per bit |
| done_o | output | 1 | Total completion: 1 = all bits valid, 0 = all bits spacer |
| data_o | output | N | Decoded word while `done_o` is 1, otherwise zero |
| err_o | output | 1 | Registered flag for a (1,1) code on any bit |

## Verification
A C-element stuck in the wrong state inside the tree shows up at `done_o` as an edge that arrives early, arrives late or never arrives. The bench sees this within the D-cycle window after each full word or full spacer. A node that fails to hold shows up as a toggle of `done_o` during a long mixed-bus interval. A wrong padding leaf shows up only for the patterns that use the top bit, which is why every word of a non-power-of-two configuration is swept. Decode faults show up at `data_o` or `err_o` one cycle after the stimulus.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Code on one bit, written as {true rail, false rail}
  typedef enum logic [1:0] {
    CODE_SPACER = 2'b00,
    CODE_ZERO   = 2'b01,
    CODE_ONE    = 2'b10,
    CODE_BAD    = 2'b11
  } rail_code_e;
endpackage

// File: rtl/dr_bit_decode.sv
module dr_bit_decode
  import dr_pkg::*;
(
  input  logic t_i,
  input  logic f_i,
  output logic full_o,
  output logic value_o,
  output logic bad_o
);
  rail_code_e code;

  always_comb begin
    code    = rail_code_e'({t_i, f_i});
    full_o  = 1'b1;
    value_o = 1'b0;
    bad_o   = 1'b0;
    case (code)
      CODE_SPACER: full_o = 1'b0;
      CODE_ZERO:   value_o = 1'b0;
      CODE_ONE:    value_o = 1'b1;
      default:     bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dr_c_elem.sv
module dr_c_elem (
  input  logic clk,
  input  logic rst,
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);
  logic state_q;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= 1'b0;
    else if (a_i && b_i)
      state_q <= 1'b1;
    else if (!a_i && !b_i)
      state_q <= 1'b0;
  end

  assign y_o = state_q;

  assert_set_R9: assert property (@(posedge clk) disable iff (rst)
    (a_i && b_i) |=> y_o);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!a_i && !b_i) |=> !y_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (a_i != b_i) |=> $stable(y_o));
endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_i,
  output logic         root_o
);
  localparam int DEPTH  = (N < 2) ? 1 : $clog2(N);
  localparam int LEAVES = 1 << DEPTH;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node 0 is the root, children of k are 2k+1 and 2k+2
  logic [NODES-1:0] node;

  genvar j;
  generate
    for (j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < N) begin : g_real
        assign node[LEAVES-1+j] = flag_i[j];
      end else begin : g_pad
        assign node[LEAVES-1+j] = flag_i[N-1];  // R10 padding copies top bit
      end
    end
    for (j = 0; j < LEAVES - 1; j++) begin : g_node
      dr_c_elem u_c (
        .clk (clk),
        .rst (rst),
        .a_i (node[2*j+1]),
        .b_i (node[2*j+2]),
        .y_o (node[j])
      );
    end
  endgenerate

  assign root_o = node[0];
endmodule

// File: rtl/dr_completion_tree.sv
module dr_completion_tree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  output logic         done_o,
  output logic [N-1:0] data_o,
  output logic         err_o
);
  logic [N-1:0] full;
  logic [N-1:0] value;
  logic [N-1:0] bad;
  logic         root;
  logic [N-1:0] data_q;
  logic         err_q;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      dr_bit_decode u_dec (
        .t_i     (rail_t[i]),
        .f_i     (rail_f[i]),
        .full_o  (full[i]),
        .value_o (value[i]),
        .bad_o   (bad[i])
      );
    end
  endgenerate

  dr_c_tree #(.N(N)) u_tree (
    .clk    (clk),
    .rst    (rst),
    .flag_i (full),
    .root_o (root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      data_q <= value;
      err_q  <= |bad;
    end
  end

  assign done_o = root;
  assign data_o = root ? data_q : '0;
  assign err_o  = err_q;

  assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|bad) |=> err_o);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !(|bad) |=> !err_o);
  assert_data_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (data_o == '0));
endmodule

// File: tb/tb_dr_completion_tree.sv
`timescale 1ns/1ps
module tb_dr_completion_tree;
  localparam int N = 6;
  localparam int D = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] rail_t = '0;
  logic [N-1:0] rail_f = '0;
  logic         done_o;
  logic [N-1:0] data_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_completion_tree #(.N(N)) dut (
    .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
    .done_o(done_o), .data_o(data_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive word w on bits in mask, spacer elsewhere
  task automatic drive(input logic [N-1:0] w, input logic [N-1:0] mask);
    rail_t = w & mask;
    rail_f = ~w & mask;
  endtask

  initial begin
    cyc(3);
    chk("R2 done", done_o, 0);
    chk("R2 data", data_o, 0);
    chk("R2 err", err_o, 0);
    rst = 1'b0;
    cyc(2);

    // exhaustive sweep over all words (R1, R3, R4, R7, R10)
    for (int w = 0; w < (1 << N); w++) begin
      drive(w[N-1:0], '1);
      cyc(D - 1);
      chk("R3 not early", done_o, 0);
      cyc(1);
      chk("R3 rise", done_o, 1);
      chk("R7 R1 data", data_o, w);
      drive('0, '0);
      cyc(D - 1);
      chk("R4 not early", done_o, 1);
      cyc(1);
      chk("R4 fall", done_o, 0);
      chk("R7 zero", data_o, 0);
    end

    // mixed bus while low, every partial mask (R5, R10)
    for (int m = 1; m < (1 << N) - 1; m++) begin
      drive(6'h2A, m[N-1:0]);
      cyc(8);
      chk("R5 hold low", done_o, 0);
      chk("R7 zero while low", data_o, 0);
      drive('0, '0);
      cyc(D + 1);
    end

    // mixed bus while high (R6)
    for (int m = 1; m < (1 << N) - 1; m++) begin
      drive(6'h15, '1);
      cyc(D + 1);
      drive(6'h15, m[N-1:0]);
      cyc(8);
      chk("R6 hold high", done_o, 1);
      drive('0, '0);
      cyc(D + 1);
      chk("R4 cleared", done_o, 0);
    end

    // illegal code on each bit (R8, R1)
    for (int b = 0; b < N; b++) begin
      rail_t = '0; rail_f = '0;
      rail_t[b] = 1'b1; rail_f[b] = 1'b1;
      cyc(1);
      chk("R8 err set", err_o, 1);
      rail_t = '0; rail_f = '0;
      cyc(1);
      chk("R8 err clear", err_o, 0);
      cyc(D + 1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule